// File: doc/BRIEF.md
# Operand Effective Address Generator

This block resolves one source or destination operand of a CISC processor that has eight data registers and eight address registers. Each cycle it takes an addressing-mode code, a register number, an operand size, the program counter and up to two extension words that have already been fetched. The whole register file is supplied as one flat bus. One cycle later it presents the result. The result is either an operand value that needs no memory access (register contents, quick data or immediate data) or a 32-bit memory address that the bus side must fetch.

For the auto-increment and auto-decrement modes, the block also produces a write-back request that carries the updated address-register value. It reports how many extension words the mode consumed so that the fetch unit can advance past them. A mode code that has no meaning raises an illegal-mode flag and produces no side effect. The block contains no instruction decode and no bus access.

Top module: `opea_gen`

## Requirements
- R1: The outputs are registered, so each result appears on the clock edge after its inputs. While `rst_n` is low at a clock edge, every output is cleared to zero.
- R2: Register file layout: `gpr_i` bits [32k+31:32k] hold data register k and bits [32(8+k)+31:32(8+k)] hold address register k. Mode 0 returns data register `reg_sel_i` and mode 1 returns address register `reg_sel_i`. Mode 12 returns `quick_i` unchanged. All three modes set `fetch_o`=0 and `ext_used_o`=0.
- R3: Mode 11 (immediate) sets `fetch_o`=0 and returns data that depends on the size code. Byte (00) zero-extends `ext0_i[7:0]` and word (01) zero-extends `ext0_i`; both report `ext_used_o`=1. Long returns {`ext0_i`,`ext1_i`} and reports `ext_used_o`=2.
- R4: Mode 2 returns address register `reg_sel_i` as the address, with `fetch_o`=1, no write-back and `ext_used_o`=0.
- R5: Mode 3 (postincrement) returns the old register value as the address. It requests write-back of that value plus the step.
- R6: Mode 4 (predecrement) subtracts the step from the register. It returns the decremented value as the address and requests write-back of the same value.
- R7: Size codes are 00 byte, 01 word, and 10 or 11 long. The step is 2 for word and 4 for long. For byte it is 1, except for address register 7, whose step is 2.
- R8: Mode 5 returns address register `reg_sel_i` plus the sign-extended `ext0_i`, with `ext_used_o`=1.
- R9: Mode 6 returns address register `reg_sel_i` plus the sign-extended `ext0_i[7:0]` plus an index, with `ext_used_o`=1. The index register is chosen by `ext0_i[15]` (1 for an address register, 0 for a data register) and by the number in `ext0_i[14:12]`. When `ext0_i[11]`=1 the index is the full 32-bit register; otherwise it is the sign-extended low 16 bits of that register.
- R10: Mode 7 returns the sign-extended `ext0_i` with `ext_used_o`=1. Mode 8 returns {`ext0_i`,`ext1_i`} with `ext_used_o`=2.
- R11: Modes 9 and 10 compute like modes 5 and 6, except that the base is `pc_i`, the address of the first extension word.
- R12: Mode codes 13, 14 and 15 set `illegal_o`=1 and drive `operand_o`=0, `fetch_o`=0, `wb_en_o`=0 and `ext_used_o`=0.
- R13: `wb_en_o` is 1 only for modes 3 and 4. When it is 1, `wb_reg_o` equals `reg_sel_i`; otherwise `wb_reg_o` and `wb_val_o` are 0. All memory modes (2 to 10) set `fetch_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 4 | Addressing-mode code |
| reg_sel_i | input | 3 | Register number from the opcode |
| size_i | input | 2 | Operand size code |
| pc_i | input | 32 | Address of the first extension word |
| ext0_i | input | 16 | First extension word |
| ext1_i | input | 16 | Second extension word |
| quick_i | input | 32 | Quick data decoded from the opcode |
| gpr_i | input | 512 | Flat register file, data registers then address registers |
| operand_o | output | 32 | Operand value or memory address |
| fetch_o | output | 1 | 1 when `operand_o` is an address to fetch |
| wb_en_o | output | 1 | Address-register write-back request |
| wb_reg_o | output | 3 | Address register to write back |
| wb_val_o | output | 32 | Value to write back |
| ext_used_o | output | 2 | Extension words consumed |
| illegal_o | output | 1 | Unsupported mode code |

## Verification
The bench sweeps all sixteen mode codes, all eight register numbers and all four size codes. Each combination is tried with six extension-word patterns. The patterns cover positive and negative 16-bit displacements, and index words that select data or address registers with word or long indexing and with positive or negative 8-bit offsets. The register file mixes values whose low half is negative with values whose low half is positive. This separates a sign-extended word index from a full long index, and a sign-extended displacement from a zero-extended one. The sweep over register 7 at byte size separates the stack step from the ordinary byte step. The pre- and post-modification addresses tell the two auto-modify orderings apart.

// File: rtl/opea_pkg.sv
// Package: shared mode and size codes for the operand address generator.
// Assumes a 4-bit mode field and a 2-bit size field.
package opea_pkg;

    typedef enum logic [3:0] {
        AM_DREG    = 4'd0,
        AM_AREG    = 4'd1,
        AM_IND     = 4'd2,
        AM_POSTINC = 4'd3,
        AM_PREDEC  = 4'd4,
        AM_DISP    = 4'd5,
        AM_INDEX   = 4'd6,
        AM_ABS_S   = 4'd7,
        AM_ABS_L   = 4'd8,
        AM_PC_DISP = 4'd9,
        AM_PC_IDX  = 4'd10,
        AM_IMM     = 4'd11,
        AM_QUICK   = 4'd12,
        AM_RSV13   = 4'd13,
        AM_RSV14   = 4'd14,
        AM_RSV15   = 4'd15
    } am_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;

endpackage

// File: rtl/opea_step.sv
// Module: opea_step
// Produces the auto-modify step for a given operand size and address register.
// Assumes that size[1] set means long. The byte step is taken from a table built
// per register, and the stack register gets 2 so that it stays word aligned.
module opea_step #(
    parameter int NREG      = 8,
    parameter int STACK_REG = 7,
    localparam int RSEL_W   = $clog2(NREG)
) (
    input  logic [1:0]        size_i,
    input  logic [RSEL_W-1:0] reg_sel_i,
    output logic [2:0]        step_o
);
    import opea_pkg::*;

    logic [2:0] byte_step [NREG];

    // Build the per-register byte step table.
    for (genvar g = 0; g < NREG; g++) begin : g_bstep
        assign byte_step[g] = (g == STACK_REG) ? 3'd2 : 3'd1;
    end

    // Select the step from the size code.
    always_comb begin
        if (size_i[1])             step_o = 3'd4;
        else if (size_i == SZ_WORD) step_o = 3'd2;
        else                        step_o = byte_step[reg_sel_i];
    end
endmodule

// File: rtl/opea_index.sv
// Module: opea_index
// Decodes a brief index extension word into one offset: the sign-extended
// 8-bit displacement plus the sized index register value.
// Assumes 8 data and 8 address registers packed data-first in gpr_i.
module opea_index #(
    parameter int XLEN = 32,
    parameter int NREG = 8,
    localparam int RF_W = 2 * NREG * XLEN
) (
    input  logic [4:0]      ctl_i,   // extension bits 15..11
    input  logic [7:0]      disp_i,  // extension bits 7..0
    input  logic [RF_W-1:0] gpr_i,
    output logic [XLEN-1:0] offset_o
);
    logic [3:0]      flat_idx;
    logic [XLEN-1:0] idx_raw;
    logic [XLEN-1:0] idx_sized;

    // Pick the index register: the type bit selects the upper bank.
    always_comb begin
        flat_idx = {ctl_i[4], ctl_i[3:1]};
        idx_raw  = gpr_i[flat_idx*XLEN +: XLEN];
    end

    // Size the index and add the short displacement.
    always_comb begin
        idx_sized = ctl_i[0] ? idx_raw : {{(XLEN-16){idx_raw[15]}}, idx_raw[15:0]};
        offset_o  = idx_sized + {{(XLEN-8){disp_i[7]}}, disp_i};
    end
endmodule

// File: rtl/opea_core.sv
// Module: opea_core
// Combinational mode multiplexer: forms the operand value or address, the
// write-back request and the extension word count for one operand.
// Assumes the pc input is the address of the first extension word.
module opea_core #(
    parameter int XLEN      = 32,
    parameter int NREG      = 8,
    parameter int STACK_REG = 7,
    localparam int RSEL_W   = $clog2(NREG),
    localparam int RF_W     = 2 * NREG * XLEN
) (
    input  opea_pkg::am_e     mode_i,
    input  logic [RSEL_W-1:0] reg_sel_i,
    input  logic [1:0]        size_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [15:0]       ext0_i,
    input  logic [15:0]       ext1_i,
    input  logic [XLEN-1:0]   quick_i,
    input  logic [RF_W-1:0]   gpr_i,
    output logic [XLEN-1:0]   operand_o,
    output logic              fetch_o,
    output logic              wb_en_o,
    output logic [RSEL_W-1:0] wb_reg_o,
    output logic [XLEN-1:0]   wb_val_o,
    output logic [1:0]        ext_used_o,
    output logic              illegal_o
);
    import opea_pkg::*;

    logic [2:0]      step;
    logic [XLEN-1:0] idx_off;
    logic [XLEN-1:0] dreg, areg, disp16, step_x, a_dec;

    opea_step #(.NREG(NREG), .STACK_REG(STACK_REG)) u_step (
        .size_i    (size_i),
        .reg_sel_i (reg_sel_i),
        .step_o    (step)
    );

    opea_index #(.XLEN(XLEN), .NREG(NREG)) u_index (
        .ctl_i    (ext0_i[15:11]),
        .disp_i   (ext0_i[7:0]),
        .gpr_i    (gpr_i),
        .offset_o (idx_off)
    );

    // Read the selected registers and form the common terms.
    always_comb begin
        dreg   = gpr_i[reg_sel_i*XLEN +: XLEN];
        areg   = gpr_i[(NREG + int'(reg_sel_i))*XLEN +: XLEN];
        disp16 = {{(XLEN-16){ext0_i[15]}}, ext0_i};
        step_x = {{(XLEN-3){1'b0}}, step};
        a_dec  = areg - step_x;
    end

    // Choose the result, the fetch flag, the write-back and the word count per mode.
    always_comb begin
        operand_o  = '0;
        fetch_o    = 1'b1;
        wb_en_o    = 1'b0;
        wb_reg_o   = '0;
        wb_val_o   = '0;
        ext_used_o = 2'd0;
        illegal_o  = 1'b0;
        case (mode_i)
            AM_DREG:  begin operand_o = dreg;    fetch_o = 1'b0; end
            AM_AREG:  begin operand_o = areg;    fetch_o = 1'b0; end
            AM_QUICK: begin operand_o = quick_i; fetch_o = 1'b0; end
            AM_IMM: begin
                fetch_o = 1'b0;
                if (size_i[1]) begin
                    operand_o  = {ext0_i, ext1_i};
                    ext_used_o = 2'd2;
                end else begin
                    operand_o  = (size_i == SZ_BYTE) ? {{(XLEN-8){1'b0}}, ext0_i[7:0]}
                                                     : {{(XLEN-16){1'b0}}, ext0_i};
                    ext_used_o = 2'd1;
                end
            end
            AM_IND: operand_o = areg;
            AM_POSTINC: begin
                operand_o = areg;
                wb_en_o   = 1'b1;
                wb_reg_o  = reg_sel_i;
                wb_val_o  = areg + step_x;
            end
            AM_PREDEC: begin
                operand_o = a_dec;
                wb_en_o   = 1'b1;
                wb_reg_o  = reg_sel_i;
                wb_val_o  = a_dec;
            end
            AM_DISP:    begin operand_o = areg + disp16;    ext_used_o = 2'd1; end
            AM_INDEX:   begin operand_o = areg + idx_off;   ext_used_o = 2'd1; end
            AM_ABS_S:   begin operand_o = disp16;           ext_used_o = 2'd1; end
            AM_ABS_L:   begin operand_o = {ext0_i, ext1_i}; ext_used_o = 2'd2; end
            AM_PC_DISP: begin operand_o = pc_i + disp16;    ext_used_o = 2'd1; end
            AM_PC_IDX:  begin operand_o = pc_i + idx_off;   ext_used_o = 2'd1; end
            default: begin
                fetch_o   = 1'b0;
                illegal_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/opea_gen.sv
// Module: opea_gen (top)
// Operand effective address generator with one registered output stage.
// Assumes that the extension words are already fetched and that pc_i points at
// the first of them. All outputs clear under a synchronous active-low reset.
module opea_gen #(
    parameter int XLEN      = 32,
    parameter int NREG      = 8,
    parameter int STACK_REG = 7,
    localparam int RSEL_W   = $clog2(NREG),
    localparam int RF_W     = 2 * NREG * XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mode_i,
    input  logic [RSEL_W-1:0] reg_sel_i,
    input  logic [1:0]        size_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [15:0]       ext0_i,
    input  logic [15:0]       ext1_i,
    input  logic [XLEN-1:0]   quick_i,
    input  logic [RF_W-1:0]   gpr_i,
    output logic [XLEN-1:0]   operand_o,
    output logic              fetch_o,
    output logic              wb_en_o,
    output logic [RSEL_W-1:0] wb_reg_o,
    output logic [XLEN-1:0]   wb_val_o,
    output logic [1:0]        ext_used_o,
    output logic              illegal_o
);
    import opea_pkg::*;

    logic [XLEN-1:0]   c_operand, c_wb_val;
    logic              c_fetch, c_wb_en, c_illegal;
    logic [RSEL_W-1:0] c_wb_reg;
    logic [1:0]        c_ext;

    opea_core #(.XLEN(XLEN), .NREG(NREG), .STACK_REG(STACK_REG)) u_core (
        .mode_i     (am_e'(mode_i)),
        .reg_sel_i  (reg_sel_i),
        .size_i     (size_i),
        .pc_i       (pc_i),
        .ext0_i     (ext0_i),
        .ext1_i     (ext1_i),
        .quick_i    (quick_i),
        .gpr_i      (gpr_i),
        .operand_o  (c_operand),
        .fetch_o    (c_fetch),
        .wb_en_o    (c_wb_en),
        .wb_reg_o   (c_wb_reg),
        .wb_val_o   (c_wb_val),
        .ext_used_o (c_ext),
        .illegal_o  (c_illegal)
    );

    // Register the result bundle; clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            operand_o  <= '0;
            fetch_o    <= 1'b0;
            wb_en_o    <= 1'b0;
            wb_reg_o   <= '0;
            wb_val_o   <= '0;
            ext_used_o <= 2'd0;
            illegal_o  <= 1'b0;
        end else begin
            operand_o  <= c_operand;
            fetch_o    <= c_fetch;
            wb_en_o    <= c_wb_en;
            wb_reg_o   <= c_wb_reg;
            wb_val_o   <= c_wb_val;
            ext_used_o <= c_ext;
            illegal_o  <= c_illegal;
        end
    end

    logic [XLEN-1:0] post_gap;
    assign post_gap = wb_val_o - operand_o;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        (!$past(rst_n)) |-> (operand_o == '0 && !fetch_o && !wb_en_o && ext_used_o == 2'd0 && !illegal_o));
    // R5
    postinc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == 4'd3) |-> (wb_en_o && $countones(post_gap) == 1 && post_gap < 5));
    // R6
    predec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == 4'd4) |-> (wb_en_o && wb_val_o == operand_o));
    // R12
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wb_en_o && !fetch_o && ext_used_o == 2'd0));
    // R13
    wb_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (fetch_o && !illegal_o));
    // R10
    ext_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_used_o != 2'd3);
endmodule

// File: tb/opea_gen_test.sv
// Bench for opea_gen: sweeps every mode, register, size and several extension
// patterns, and compares the outputs against arithmetic expectations.
module opea_gen_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [3:0]   mode;
    logic [2:0]   rsel;
    logic [1:0]   size;
    logic [31:0]  pc;
    logic [15:0]  ext0, ext1;
    logic [31:0]  quick;
    logic [511:0] gpr;
    logic [31:0]  operand, wb_val;
    logic         fetch, wb_en, illegal;
    logic [2:0]   wb_reg;
    logic [1:0]   ext_used;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] rf [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    opea_gen uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .reg_sel_i(rsel), .size_i(size),
        .pc_i(pc), .ext0_i(ext0), .ext1_i(ext1), .quick_i(quick), .gpr_i(gpr),
        .operand_o(operand), .fetch_o(fetch), .wb_en_o(wb_en), .wb_reg_o(wb_reg),
        .wb_val_o(wb_val), .ext_used_o(ext_used), .illegal_o(illegal)
    );

    function automatic string req_of(input int m);
        case (m)
            0, 1, 12: return "R2";
            2:        return "R4";
            3:        return "R5 R7";
            4:        return "R6 R7";
            5:        return "R8";
            6:        return "R9";
            7, 8:     return "R10";
            9, 10:    return "R11";
            11:       return "R3";
            default:  return "R12";
        endcase
    endfunction

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] idx_off(input logic [15:0] e);
        logic [31:0] v;
        v = rf[{e[15], e[14:12]}];
        return (e[11] ? v : sx16(v[15:0])) + {{24{e[7]}}, e[7:0]};
    endfunction

    task automatic check_case(input int m, input int r, input int s);
        logic [31:0] e_op, e_wv, a, st;
        logic e_f, e_we, e_il;
        logic [2:0] e_wr;
        logic [1:0] e_x;
        a = rf[8+r];
        st = s[1] ? 4 : (s == 1 ? 2 : (r == 7 ? 2 : 1));   // R7
        e_op = 0; e_f = 1; e_we = 0; e_wr = 0; e_wv = 0; e_x = 0; e_il = 0;
        case (m)
            0:  begin e_op = rf[r]; e_f = 0; end
            1:  begin e_op = a; e_f = 0; end
            12: begin e_op = quick; e_f = 0; end
            11: begin
                e_f = 0;
                if (s[1]) begin e_op = {ext0, ext1}; e_x = 2; end
                else begin e_op = (s == 0) ? {24'd0, ext0[7:0]} : {16'd0, ext0}; e_x = 1; end
            end
            2:  e_op = a;
            3:  begin e_op = a; e_we = 1; e_wr = 3'(r); e_wv = a + st; end
            4:  begin e_op = a - st; e_we = 1; e_wr = 3'(r); e_wv = a - st; end
            5:  begin e_op = a + sx16(ext0); e_x = 1; end
            6:  begin e_op = a + idx_off(ext0); e_x = 1; end
            7:  begin e_op = sx16(ext0); e_x = 1; end
            8:  begin e_op = {ext0, ext1}; e_x = 2; end
            9:  begin e_op = pc + sx16(ext0); e_x = 1; end
            10: begin e_op = pc + idx_off(ext0); e_x = 1; end
            default: begin e_f = 0; e_il = 1; end
        endcase
        checks++;
        if (operand !== e_op || fetch !== e_f || wb_en !== e_we || wb_reg !== e_wr ||
            wb_val !== e_wv || ext_used !== e_x || illegal !== e_il) begin
            errors++;
            $display("FAIL %s mode=%0d reg=%0d size=%0d ext0=%h: got op=%h f=%b we=%b wr=%0d wv=%h x=%0d il=%b exp op=%h f=%b we=%b wr=%0d wv=%h x=%0d il=%b",
                     req_of(m), m, r, s, ext0, operand, fetch, wb_en, wb_reg, wb_val, ext_used, illegal,
                     e_op, e_f, e_we, e_wr, e_wv, e_x, e_il);
        end
    endtask

    initial begin
        logic [15:0] pats [6];
        pats[0] = 16'h0004; pats[1] = 16'hFFF0; pats[2] = 16'h9880;
        pats[3] = 16'h3020; pats[4] = 16'h7F7F; pats[5] = 16'hE0FE;
        for (int i = 0; i < 16; i++) begin
            rf[i] = (i % 2 == 1) ? (32'h0101_0000 * i + 32'h8000 + i * 32'h111)
                                 : (32'h7F01_0000 - 32'h0100_0000 * i + i * 32'h111);
            gpr[i*32 +: 32] = rf[i];
        end
        rst_n = 1'b0; mode = 4'd5; rsel = 3'd1; size = 2'd1; pc = 32'h0000_4F00;
        ext0 = 16'h1234; ext1 = 16'h5A3C; quick = 32'hFFFF_FFFD;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (operand !== 0 || fetch !== 0 || wb_en !== 0 || wb_val !== 0 || ext_used !== 0 || illegal !== 0) begin
            errors++;
            $display("FAIL R1 reset: got op=%h f=%b we=%b x=%0d il=%b exp all zero", operand, fetch, wb_en, ext_used, illegal);
        end
        rst_n = 1'b1;
        for (int m = 0; m < 16; m++)
            for (int r = 0; r < 8; r++)
                for (int s = 0; s < 4; s++)
                    for (int p = 0; p < 6; p++) begin
                        mode = 4'(m); rsel = 3'(r); size = 2'(s); ext0 = pats[p];
                        ext1 = 16'h5A3C ^ 16'(p);
                        @(negedge clk);
                        check_case(m, r, s);   // R13 checked in every case
                    end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule